// File: doc/BRIEF.md
# Stop-Gated Network Controller Register Bank

This block is a bank of 16-bit configuration and status registers for a network controller. Software reaches it through an indexed register port: a register index, a write strobe, write data and combinational read data. It holds the receive and transmit ring-length codes, a 64-bit multicast hash filter, a 48-bit station address, and a jabber status bit with its interrupt mask. An initialization sequencer has its own load port and can fill the ring lengths, the filter and the station address.

Access to the configuration words depends on a controller halt level (`stop_i`). While the controller is halted, software may read and write the filter and address words and read the ring lengths. While it runs, those words read as zero and writes to them are dropped. The status word is always reachable. The jabber bit is write-one-to-clear, and its unmasked state drives the interrupt output. A serializer presents the station address one bit at a time, lowest bit first, for the transmit path.

Top module: `ctl_regbank`

## Requirements
- R1: A `jab_pulse` cycle with `stop_i` low sets the jabber status bit (index 0, bit 0) at the next clock edge. A pulse wins over a software clear in the same cycle.
- R2: Writing index 0 with bit 0 = 1 clears the jabber status. Writing bit 0 = 0 leaves it unchanged. The clear works while the jabber pulse source is still active between pulses.
- R3: While `stop_i` is high, the jabber status is cleared at each clock edge and held clear, and this overrides a pulse.
- R4: The jabber mask is index 0, bit 1. It resets to 1 and is writable whatever `stop_i` is. `stop_i` never changes it. `irq` is high exactly when the status is 1 and the mask is 0.
- R5: Index 1 holds the transmit ring-length code in bits 15:12 and the receive code in bits 11:8. Bits 7:0 read 0. Software writes to it have no effect. It reads 0 while `stop_i` is low.
- R6: The filter occupies indices 2 to 5 and the station address occupies indices 6 to 8, each with its lowest 16 bits at the lowest index. Software can read and write them only while `stop_i` is high. Otherwise they read 0 and writes are ignored.
- R7: An initialization load (`init_we`) writes index 1, 2 to 5 or 6 to 8 whatever `stop_i` is. When it targets the same index as a software write in the same cycle, the load value is kept.
- R8: After reset, the status reads 0x0002 and `irq` is 0. With `stop_i` high, indices 1 to 8 read 0. Reset asserts asynchronously, and its release takes effect after two clock edges.
- R9: `pa_load` captures the 48-bit station address, and `pa_bit` then shows address bit 0. Each `pa_shift` cycle moves it to the next higher bit, up to bit 47. A load wins over a shift in the same cycle.
- R10: Indices 9 to 15 always read 0, and bits 15:2 of index 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Controller halted; opens configuration access |
| reg_addr | input | 4 | Register index for software access |
| reg_we | input | 1 | Software write strobe |
| reg_wdata | input | 16 | Software write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| init_we | input | 1 | Initialization load strobe |
| init_addr | input | 4 | Initialization load index |
| init_wdata | input | 16 | Initialization load data |
| jab_pulse | input | 1 | One-cycle jabber detection pulse |
| irq | output | 1 | Unmasked jabber interrupt contribution |
| pa_load | input | 1 | Capture station address into the serializer |
| pa_shift | input | 1 | Advance the serializer by one bit |
| pa_bit | output | 1 | Current serialized station-address bit |

## Verification
The jabber logic is swept over all 16 combinations of prior status, pulse, clear bit and halt level. This separates the priority order stop, then set, then clear from every other ordering. The configuration words are filled with arithmetically distinct patterns with the controller halted and then running. The patterns show swapped word indices, leaking read gating and writes accepted while running. Simultaneous initialization and software writes to the same index and to different indices separate load priority from lost writes. Shifting out all 48 address bits exposes bit-order and word-order errors.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int LAF_WORDS = 4;
  localparam int PA_WORDS = 3;
  localparam int RING_W = 8;
  localparam logic [AW-1:0] IDX_STAT = 4'd0;
  localparam logic [AW-1:0] IDX_RING = 4'd1;
  localparam logic [AW-1:0] IDX_LAF0 = 4'd2;
  localparam logic [AW-1:0] IDX_PA0  = 4'd6;
  localparam int STAT_JAB_BIT  = 0;
  localparam int STAT_MASK_BIT = 1;
endpackage

// File: rtl/rb_wordfile.sv
module rb_wordfile #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int N = 4,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            stop_i,
  input  logic            sw_we,
  input  logic [AW-1:0]   sw_addr,
  input  logic [DW-1:0]   sw_wdata,
  input  logic            in_we,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_wdata,
  output logic [N*DW-1:0] words_o
);
  for (genvar i = 0; i < N; i++) begin : g_word
    localparam logic [AW-1:0] MY_IDX = BASE + AW'(i);
    logic [DW-1:0] word_q, word_d;
    logic          word_en;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (in_we && in_addr == MY_IDX) begin
        word_en = 1'b1;
        word_d  = in_wdata;
      end else if (sw_we && stop_i && sw_addr == MY_IDX) begin
        word_en = 1'b1;
        word_d  = sw_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign words_o[i*DW +: DW] = word_q;
  end
endmodule

// File: rtl/rb_jabber.sv
module rb_jabber (
  input  logic clk,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic pulse_i,
  input  logic stat_wr_i,
  input  logic clr_bit_i,
  input  logic mask_bit_i,
  output logic status_o,
  output logic mask_o,
  output logic irq_o
);
  logic status_q, status_d;
  logic mask_q, mask_d;

  always_comb begin
    status_d = status_q;
    if (stop_i)                      status_d = 1'b0;
    else if (pulse_i)                status_d = 1'b1;
    else if (stat_wr_i && clr_bit_i) status_d = 1'b0;
  end

  always_comb begin
    mask_d = stat_wr_i ? mask_bit_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      mask_q   <= 1'b1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = status_q & ~mask_q;
endmodule

// File: rtl/rb_serial.sv
module rb_serial #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         sh_i,
  input  logic [W-1:0] par_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = ld_i | sh_i;
    if (ld_i) sr_d = par_i;
    else      sr_d = {1'b0, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign bit_o = sr_q[0];
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_i,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [DW-1:0] init_wdata,
  input  logic          jab_pulse,
  output logic          irq,
  input  logic          pa_load,
  input  logic          pa_shift,
  output logic          pa_bit
);
  localparam int LAF_BITS = LAF_WORDS * DW;
  localparam int PA_BITS  = PA_WORDS * DW;

  logic [1:0] rst_pipe_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  logic [LAF_BITS-1:0] laf_words;
  logic [PA_BITS-1:0]  pa_words;
  logic [RING_W-1:0]   ring_q, ring_d;
  logic                ring_en;
  logic                jab_q, mask_q;
  logic                stat_wr;

  rb_wordfile #(.DW(DW), .AW(AW), .N(LAF_WORDS), .BASE(IDX_LAF0)) u_laf (
    .clk(clk), .rst_ni(rst_s), .stop_i(stop_i),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata),
    .in_we(init_we), .in_addr(init_addr), .in_wdata(init_wdata),
    .words_o(laf_words)
  );

  rb_wordfile #(.DW(DW), .AW(AW), .N(PA_WORDS), .BASE(IDX_PA0)) u_pa (
    .clk(clk), .rst_ni(rst_s), .stop_i(stop_i),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata),
    .in_we(init_we), .in_addr(init_addr), .in_wdata(init_wdata),
    .words_o(pa_words)
  );

  always_comb begin
    ring_en = init_we && (init_addr == IDX_RING);
    ring_d  = init_wdata[DW-1 -: RING_W];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       ring_q <= '0;
    else if (ring_en) ring_q <= ring_d;
  end

  assign stat_wr = reg_we && (reg_addr == IDX_STAT);

  rb_jabber u_jab (
    .clk(clk), .rst_ni(rst_s), .stop_i(stop_i), .pulse_i(jab_pulse),
    .stat_wr_i(stat_wr), .clr_bit_i(reg_wdata[STAT_JAB_BIT]),
    .mask_bit_i(reg_wdata[STAT_MASK_BIT]),
    .status_o(jab_q), .mask_o(mask_q), .irq_o(irq)
  );

  rb_serial #(.W(PA_BITS)) u_ser (
    .clk(clk), .rst_ni(rst_s), .ld_i(pa_load), .sh_i(pa_shift),
    .par_i(pa_words), .bit_o(pa_bit)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == IDX_STAT) begin
      reg_rdata[STAT_JAB_BIT]  = jab_q;
      reg_rdata[STAT_MASK_BIT] = mask_q;
    end else if (stop_i) begin
      if (reg_addr == IDX_RING) reg_rdata = {ring_q, {(DW-RING_W){1'b0}}};
      for (int i = 0; i < LAF_WORDS; i++)
        if (reg_addr == IDX_LAF0 + AW'(i)) reg_rdata = laf_words[i*DW +: DW];
      for (int i = 0; i < PA_WORDS; i++)
        if (reg_addr == IDX_PA0 + AW'(i)) reg_rdata = pa_words[i*DW +: DW];
    end
  end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import regbank_pkg::*;
(
  input logic          clk,
  input logic          rst_s,
  input logic          stop_i,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          jab_pulse,
  input logic          irq,
  input logic          jab_st,
  input logic          mask_st
);
  p_jab_set_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (!stop_i && jab_pulse) |=> jab_st);

  p_w1c_zero_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (!stop_i && !jab_pulse && reg_we && reg_addr == IDX_STAT && !reg_wdata[0]) |=> $stable(jab_st));

  p_w1c_one_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (!stop_i && !jab_pulse && reg_we && reg_addr == IDX_STAT && reg_wdata[0]) |=> !jab_st);

  p_stop_clear_r3: assert property (@(posedge clk) disable iff (!rst_s)
    stop_i |=> !jab_st);

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_s)
    mask_st |-> !irq);

  p_ring_low_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_addr == IDX_RING) |-> (reg_rdata[7:0] == 8'h00));

  p_gated_read_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!stop_i && reg_addr != IDX_STAT) |-> (reg_rdata == '0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_addr > 4'd8) |-> (reg_rdata == '0));
endmodule

bind ctl_regbank ctl_regbank_chk u_chk (
  .clk(clk), .rst_s(rst_s), .stop_i(stop_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .jab_pulse(jab_pulse), .irq(irq), .jab_st(jab_q), .mask_st(mask_q)
);

// File: tb/tb_ctl_regbank.sv
`timescale 1ns/1ps
module tb_ctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n, stop_i, reg_we, init_we, jab_pulse, pa_load, pa_shift;
  logic [3:0]  reg_addr, init_addr;
  logic [15:0] reg_wdata, init_wdata;
  logic [15:0] reg_rdata;
  logic        irq, pa_bit;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] mem [0:8];

  always #4 clk = ~clk;

  ctl_regbank dut (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .init_we(init_we), .init_addr(init_addr), .init_wdata(init_wdata),
    .jab_pulse(jab_pulse), .irq(irq), .pa_load(pa_load),
    .pa_shift(pa_shift), .pa_bit(pa_bit)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [15:0] pat(input int i, input int salt);
    return 16'(((i + 1) * 16'h1357) ^ (salt * 16'h0F1D) ^ 16'hC0DE);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; stop_i = 1'b0; reg_we = 1'b0; init_we = 1'b0;
    jab_pulse = 1'b0; pa_load = 1'b0; pa_shift = 1'b0;
    reg_addr = '0; init_addr = '0; reg_wdata = '0; init_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    rd(4'd0, 16'h0002, "R8 status after reset");
    chk("R8 irq after reset", {15'b0, irq}, 16'h0000);
    stop_i = 1'b1;
    for (int i = 1; i <= 8; i++) rd(4'(i), 16'h0000, "R8 config word after reset");

    // R6 halted write/read sweep
    for (int i = 2; i <= 8; i++) begin mem[i] = pat(i, 1); wr(4'(i), mem[i]); end
    for (int i = 2; i <= 8; i++) rd(4'(i), mem[i], "R6 halted readback");
    stop_i = 1'b0;
    for (int i = 1; i <= 8; i++) rd(4'(i), 16'h0000, "R6 running read gated");
    for (int i = 2; i <= 8; i++) wr(4'(i), pat(i, 2));
    stop_i = 1'b1;
    for (int i = 2; i <= 8; i++) rd(4'(i), mem[i], "R6 running write ignored");

    // R10 unmapped
    for (int i = 9; i <= 15; i++) rd(4'(i), 16'h0000, "R10 unmapped index");

    // R5 ring length
    wr(4'd1, 16'hFFFF);
    rd(4'd1, 16'h0000, "R5 software write ignored");
    @(negedge clk); init_we = 1'b1; init_addr = 4'd1; init_wdata = 16'hABCD;
    @(negedge clk); init_we = 1'b0;
    rd(4'd1, 16'hAB00, "R5 ring fields and reserved zero");
    stop_i = 1'b0;
    rd(4'd1, 16'h0000, "R5 ring gated while running");

    // R7 init load while running, and collision priority
    @(negedge clk); init_we = 1'b1; init_addr = 4'd3; init_wdata = 16'h5AA5;
    @(negedge clk); init_we = 1'b0; mem[3] = 16'h5AA5;
    stop_i = 1'b1;
    rd(4'd3, 16'h5AA5, "R7 init load while running");
    @(negedge clk);
    init_we = 1'b1; init_addr = 4'd6; init_wdata = 16'h1111;
    reg_we = 1'b1; reg_addr = 4'd6; reg_wdata = 16'h2222;
    @(negedge clk); init_we = 1'b0; reg_we = 1'b0; mem[6] = 16'h1111;
    rd(4'd6, 16'h1111, "R7 init wins same index");
    @(negedge clk);
    init_we = 1'b1; init_addr = 4'd7; init_wdata = 16'h3333;
    reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 16'h4444;
    @(negedge clk); init_we = 1'b0; reg_we = 1'b0; mem[7] = 16'h3333; mem[8] = 16'h4444;
    rd(4'd7, 16'h3333, "R7 init different index");
    rd(4'd8, 16'h4444, "R7 software different index");

    // R9 serializer
    @(negedge clk); pa_load = 1'b1;
    @(negedge clk); pa_load = 1'b0;
    for (int k = 0; k < 48; k++) begin
      chk("R9 serial bit", {15'b0, pa_bit}, {15'b0, mem[6 + k / 16][k % 16]});
      pa_shift = 1'b1;
      @(negedge clk);
      pa_shift = 1'b0;
    end
    pa_load = 1'b1; pa_shift = 1'b1;
    @(negedge clk); pa_load = 1'b0; pa_shift = 1'b0;
    chk("R9 load wins over shift", {15'b0, pa_bit}, {15'b0, mem[6][0]});

    // R1 R2 R4 jabber basics
    stop_i = 1'b0;
    @(negedge clk); jab_pulse = 1'b1;
    @(negedge clk); jab_pulse = 1'b0;
    rd(4'd0, 16'h0003, "R1 pulse sets status");
    chk("R4 masked irq low", {15'b0, irq}, 16'h0000);
    wr(4'd0, 16'h0000);
    rd(4'd0, 16'h0001, "R2 write zero keeps status, R4 mask cleared");
    chk("R4 unmasked irq high", {15'b0, irq}, 16'h0001);
    stop_i = 1'b1;
    wr(4'd0, 16'h0002);
    rd(4'd0, 16'h0002, "R4 mask writable while halted, R3 stop cleared");
    wr(4'd0, 16'h0000);
    rd(4'd0, 16'h0000, "R4 stop leaves mask");
    stop_i = 1'b0;

    // R1 R2 R3 exhaustive priority sweep (mask = 0)
    for (int v = 0; v < 16; v++) begin
      logic ini, p, c, s, e;
      ini = v[3]; p = v[2]; c = v[1]; s = v[0];
      wr(4'd0, 16'h0001);
      if (ini) begin
        @(negedge clk); jab_pulse = 1'b1;
        @(negedge clk); jab_pulse = 1'b0;
      end
      @(negedge clk);
      stop_i = s; jab_pulse = p; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = {15'b0, c};
      @(negedge clk);
      jab_pulse = 1'b0; reg_we = 1'b0;
      #1;
      e = s ? 1'b0 : (p ? 1'b1 : (c ? 1'b0 : ini));
      chk("R1 R2 R3 status priority", reg_rdata, {15'b0, e});
      chk("R4 irq follows status", {15'b0, irq}, {15'b0, e});
      stop_i = 1'b0;
    end

    summary();
  end
endmodule